// File: doc/BRIEF.md
# Interrupt-Enable and Exception-Return Control

This unit keeps the privileged status word of a processor core together with a debug-mode flag and the load-link address register. The pipeline sends it one command per cycle: a strobe and a 3-bit opcode. Two commands turn interrupts off or on. Two commands return from an exception handler or from debug mode. One command writes the status word, and one command enters debug mode. Every command updates state on the clock edge that samples its strobe. In the cycle after that edge, the unit shows the effect as single-cycle pulses together with registered values.

A return command sends the fetch unit a new program counter with a redirect pulse. It also breaks any pending load-link reservation by setting the link address register to 1. For an exception return, the error-level bit takes priority over the exception-level bit. This bit chooses which saved PC is used, and only that bit is cleared. An interrupt-enable change raises a resync pulse, because the execution mode may have changed and the front end must refetch. Every command returns the status word that was in force before it executed.

Top module: `irq_ret_ctrl`

## Requirements
- R1: After reset the status word reads 0x00000004: error-level bit 2 is set, interrupt-enable bit 0 and exception-level bit 1 are clear, and all other bits are 0. Also after reset the debug flag is 0, the link address is 0, and every pulse output is low.
- R2: Opcode 0 (interrupts off) clears only bit 0 of the status word. It returns the previous status on old_stat_o and pulses resync_o.
- R3: Opcode 1 (interrupts on) sets only bit 0 of the status word. It returns the previous status on old_stat_o and pulses resync_o.
- R4: Opcode 2 (exception return) with bit 2 set redirects to err_pc_i and clears only bit 2.
- R5: Opcode 2 with bit 2 clear redirects to exc_pc_i and clears only bit 1.
- R6: Opcode 3 (debug return) in debug mode redirects to dbg_pc_i, clears the debug flag, and leaves the status word unchanged.
- R7: Opcode 3 outside debug mode pulses bad_cmd_o. It gives no redirect and leaves the status word, the debug flag and the link address unchanged.
- R8: Exception return and debug return both set the link address register to 1.
- R9: Opcode 4 loads the whole status word from wr_data_i and returns the old value on old_stat_o.
- R10: Opcode 5 sets the debug flag and leaves the status word unchanged.
- R11: Opcodes 6 and 7 pulse bad_cmd_o and change no state.
- R12: ll_load_i loads ll_addr_i into the link address register. A return command in the same cycle takes precedence and the result is 1.
- R13: done_o pulses for every strobed command. Every pulse output is high only in the single cycle after the edge that sampled its command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command opcode |
| wr_data_i | input | STAT_W | Data for a status write |
| exc_pc_i | input | PC_W | Saved exception PC |
| err_pc_i | input | PC_W | Saved error PC |
| dbg_pc_i | input | PC_W | Saved debug PC |
| ll_load_i | input | 1 | Load the link address register |
| ll_addr_i | input | LL_W | Link address to load |
| new_pc_o | output | PC_W | Redirect target, held between redirects |
| redirect_o | output | 1 | Redirect pulse |
| resync_o | output | 1 | Refetch pulse after an interrupt-enable change |
| done_o | output | 1 | Command completion pulse |
| bad_cmd_o | output | 1 | Reserved-instruction pulse |
| old_stat_o | output | STAT_W | Status before the last command |
| stat_o | output | STAT_W | Current status word |
| dbg_mode_o | output | 1 | Debug-mode flag |
| ll_addr_o | output | LL_W | Link address register |

## Verification
The hardest case to reach is an exception return when both the error-level and exception-level bits are set. Reset never produces that state, and a first return clears the error level. The bench therefore writes the status word with opcode 4, putting both bits up, and then issues the return. It checks that only the error level falls and that the error PC is chosen. Debug return is reached in both legal and illegal form by first issuing it before the debug-entry command, and then issuing it again after that command in the same cycle as a link-address load.

// File: rtl/irq_ret_pkg.sv
package irq_ret_pkg;
   typedef logic [2:0] op_t;

   localparam op_t OP_IRQ_OFF   = 3'd0;
   localparam op_t OP_IRQ_ON    = 3'd1;
   localparam op_t OP_EXC_RET   = 3'd2;
   localparam op_t OP_DBG_RET   = 3'd3;
   localparam op_t OP_STAT_WR   = 3'd4;
   localparam op_t OP_DBG_ENTER = 3'd5;

   // one-hot decoded command, at most one field high
   typedef struct packed {
      logic irq_off;
      logic irq_on;
      logic exc_ret;
      logic dbg_ret;
      logic stat_wr;
      logic dbg_enter;
      logic bad;
   } cmd_dec_t;
endpackage

// File: rtl/irq_ret_decode.sv
module irq_ret_decode
   import irq_ret_pkg::*;
(
   input  logic     valid_i,
   input  op_t      op_i,
   input  logic     dbg_mode_i,
   output cmd_dec_t dec_o
);
   always_comb begin
      dec_o = '0;
      if (valid_i) begin
         case (op_i)
            OP_IRQ_OFF:   dec_o.irq_off   = 1'b1;
            OP_IRQ_ON:    dec_o.irq_on    = 1'b1;
            OP_EXC_RET:   dec_o.exc_ret   = 1'b1;
            OP_DBG_RET: begin
               if (dbg_mode_i) dec_o.dbg_ret = 1'b1;
               else            dec_o.bad     = 1'b1;
            end
            OP_STAT_WR:   dec_o.stat_wr   = 1'b1;
            OP_DBG_ENTER: dec_o.dbg_enter = 1'b1;
            default:      dec_o.bad       = 1'b1;
         endcase
      end
   end

   // R11, R13: a strobe maps to exactly one command, no strobe to none
   always_comb begin
      if (!$isunknown({valid_i, op_i, dbg_mode_i})) begin
         p_dec_onehot_r13: assert ($countones(dec_o) == (valid_i ? 1 : 0));
      end
   end
endmodule

// File: rtl/irq_ret_status.sv
module irq_ret_status
   import irq_ret_pkg::*;
#(
   parameter int STAT_W  = 32,
   parameter int IE_POS  = 0,
   parameter int EXL_POS = 1,
   parameter int ERL_POS = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              valid_i,
   input  cmd_dec_t          dec_i,
   input  logic [STAT_W-1:0] wr_data_i,
   output logic [STAT_W-1:0] stat_o,
   output logic [STAT_W-1:0] old_stat_o
);
   localparam logic [STAT_W-1:0] IE_M   = STAT_W'(1) << IE_POS;
   localparam logic [STAT_W-1:0] EXL_M  = STAT_W'(1) << EXL_POS;
   localparam logic [STAT_W-1:0] ERL_M  = STAT_W'(1) << ERL_POS;
   localparam logic [STAT_W-1:0] RST_VAL = ERL_M;

   logic [STAT_W-1:0] stat_q, stat_d, old_q;
   logic              erl_now;

   assign erl_now = stat_q[ERL_POS];

   for (genvar b = 0; b < STAT_W; b++) begin : g_bit
      if (b == IE_POS) begin : g_ie
         assign stat_d[b] = dec_i.irq_on  ? 1'b1 :
                            dec_i.irq_off ? 1'b0 :
                            dec_i.stat_wr ? wr_data_i[b] : stat_q[b];
      end else if (b == EXL_POS) begin : g_exl
         assign stat_d[b] = (dec_i.exc_ret && !erl_now) ? 1'b0 :
                            dec_i.stat_wr ? wr_data_i[b] : stat_q[b];
      end else if (b == ERL_POS) begin : g_erl
         assign stat_d[b] = (dec_i.exc_ret && erl_now) ? 1'b0 :
                            dec_i.stat_wr ? wr_data_i[b] : stat_q[b];
      end else begin : g_plain
         assign stat_d[b] = dec_i.stat_wr ? wr_data_i[b] : stat_q[b];
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         stat_q <= RST_VAL;
         old_q  <= '0;
      end else begin
         stat_q <= stat_d;
         if (valid_i) old_q <= stat_q;
      end
   end

   assign stat_o     = stat_q;
   assign old_stat_o = old_q;

   p_irq_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dec_i.irq_off |=> (stat_q == ($past(stat_q) & ~IE_M)));
   p_irq_on_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dec_i.irq_on |=> (stat_q == ($past(stat_q) | IE_M)));
   p_eret_erl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_i.exc_ret && erl_now) |=> (stat_q == ($past(stat_q) & ~ERL_M)));
   p_eret_exl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_i.exc_ret && !erl_now) |=> (stat_q == ($past(stat_q) & ~EXL_M)));
   p_bad_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_i.bad || dec_i.dbg_ret || dec_i.dbg_enter) |=> $stable(stat_q));
   p_old_value_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> (old_q == $past(stat_q)));
endmodule

// File: rtl/irq_ret_flow.sv
module irq_ret_flow
   import irq_ret_pkg::*;
#(
   parameter int PC_W = 32
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            valid_i,
   input  cmd_dec_t        dec_i,
   input  logic            erl_i,
   input  logic [PC_W-1:0] exc_pc_i,
   input  logic [PC_W-1:0] err_pc_i,
   input  logic [PC_W-1:0] dbg_pc_i,
   output logic [PC_W-1:0] new_pc_o,
   output logic            redirect_o,
   output logic            resync_o,
   output logic            done_o,
   output logic            bad_o
);
   logic [PC_W-1:0] pc_q, pc_sel;
   logic            redir_q, sync_q, done_q, bad_q, take;

   assign take = dec_i.exc_ret || dec_i.dbg_ret;

   always_comb begin
      pc_sel = pc_q;
      if (dec_i.dbg_ret)      pc_sel = dbg_pc_i;
      else if (dec_i.exc_ret) pc_sel = erl_i ? err_pc_i : exc_pc_i;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         pc_q    <= '0;
         redir_q <= 1'b0;
         sync_q  <= 1'b0;
         done_q  <= 1'b0;
         bad_q   <= 1'b0;
      end else begin
         pc_q    <= pc_sel;
         redir_q <= take;
         sync_q  <= dec_i.irq_off || dec_i.irq_on;
         done_q  <= valid_i;
         bad_q   <= dec_i.bad;
      end
   end

   assign new_pc_o   = pc_q;
   assign redirect_o = redir_q;
   assign resync_o   = sync_q;
   assign done_o     = done_q;
   assign bad_o      = bad_q;

   p_eret_errpc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_i.exc_ret && erl_i) |=> (redir_q && pc_q == $past(err_pc_i)));
   p_eret_epc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_i.exc_ret && !erl_i) |=> (redir_q && pc_q == $past(exc_pc_i)));
   p_deret_pc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dec_i.dbg_ret |=> (redir_q && pc_q == $past(dbg_pc_i)));
   p_bad_noredir_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dec_i.bad |=> (bad_q && !redir_q && $stable(pc_q)));
   p_idle_quiet_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !(done_q || redir_q || sync_q || bad_q));
endmodule

// File: rtl/irq_ret_aux.sv
module irq_ret_aux
   import irq_ret_pkg::*;
#(
   parameter int LL_W = 32
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  cmd_dec_t        dec_i,
   input  logic            ll_load_i,
   input  logic [LL_W-1:0] ll_addr_i,
   output logic            dbg_mode_o,
   output logic [LL_W-1:0] ll_addr_o
);
   localparam logic [LL_W-1:0] LL_BREAK = LL_W'(1);

   logic            dbg_q;
   logic [LL_W-1:0] ll_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         dbg_q <= 1'b0;
         ll_q  <= '0;
      end else begin
         if (dec_i.dbg_enter)    dbg_q <= 1'b1;
         else if (dec_i.dbg_ret) dbg_q <= 1'b0;
         if (dec_i.exc_ret || dec_i.dbg_ret) ll_q <= LL_BREAK;
         else if (ll_load_i)                 ll_q <= ll_addr_i;
      end
   end

   assign dbg_mode_o = dbg_q;
   assign ll_addr_o  = ll_q;

   p_ll_break_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_i.exc_ret || dec_i.dbg_ret) |=> (ll_q == LL_BREAK));
   p_deret_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dec_i.dbg_ret |=> !dbg_q);
   p_dbg_enter_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dec_i.dbg_enter |=> dbg_q);
   p_ll_load_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ll_load_i && !dec_i.exc_ret && !dec_i.dbg_ret) |=> (ll_q == $past(ll_addr_i)));
endmodule

// File: rtl/irq_ret_ctrl.sv
module irq_ret_ctrl
   import irq_ret_pkg::*;
#(
   parameter int STAT_W  = 32,
   parameter int PC_W    = 32,
   parameter int LL_W    = 32,
   parameter int IE_POS  = 0,
   parameter int EXL_POS = 1,
   parameter int ERL_POS = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cmd_valid_i,
   input  logic [2:0]        cmd_op_i,
   input  logic [STAT_W-1:0] wr_data_i,
   input  logic [PC_W-1:0]   exc_pc_i,
   input  logic [PC_W-1:0]   err_pc_i,
   input  logic [PC_W-1:0]   dbg_pc_i,
   input  logic              ll_load_i,
   input  logic [LL_W-1:0]   ll_addr_i,
   output logic [PC_W-1:0]   new_pc_o,
   output logic              redirect_o,
   output logic              resync_o,
   output logic              done_o,
   output logic              bad_cmd_o,
   output logic [STAT_W-1:0] old_stat_o,
   output logic [STAT_W-1:0] stat_o,
   output logic              dbg_mode_o,
   output logic [LL_W-1:0]   ll_addr_o
);
   if (IE_POS >= STAT_W || EXL_POS >= STAT_W || ERL_POS >= STAT_W) begin : g_bad_pos
      $error("status bit position outside the status word");
   end
   if (IE_POS == EXL_POS || IE_POS == ERL_POS || EXL_POS == ERL_POS) begin : g_dup_pos
      $error("status bit positions must differ");
   end
   if (LL_W < 1 || PC_W < 1) begin : g_bad_w
      $error("widths must be positive");
   end

   cmd_dec_t dec;
   logic     dbg_mode;

   irq_ret_decode u_dec (
      .valid_i    (cmd_valid_i),
      .op_i       (cmd_op_i),
      .dbg_mode_i (dbg_mode),
      .dec_o      (dec)
   );

   irq_ret_status #(
      .STAT_W (STAT_W), .IE_POS (IE_POS), .EXL_POS (EXL_POS), .ERL_POS (ERL_POS)
   ) u_stat (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .valid_i    (cmd_valid_i),
      .dec_i      (dec),
      .wr_data_i  (wr_data_i),
      .stat_o     (stat_o),
      .old_stat_o (old_stat_o)
   );

   irq_ret_flow #(.PC_W (PC_W)) u_flow (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .valid_i    (cmd_valid_i),
      .dec_i      (dec),
      .erl_i      (stat_o[ERL_POS]),
      .exc_pc_i   (exc_pc_i),
      .err_pc_i   (err_pc_i),
      .dbg_pc_i   (dbg_pc_i),
      .new_pc_o   (new_pc_o),
      .redirect_o (redirect_o),
      .resync_o   (resync_o),
      .done_o     (done_o),
      .bad_o      (bad_cmd_o)
   );

   irq_ret_aux #(.LL_W (LL_W)) u_aux (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .dec_i      (dec),
      .ll_load_i  (ll_load_i),
      .ll_addr_i  (ll_addr_i),
      .dbg_mode_o (dbg_mode),
      .ll_addr_o  (ll_addr_o)
   );

   assign dbg_mode_o = dbg_mode;

   p_reset_state_r1: assert property (@(posedge clk_i)
      !rst_ni |=> (stat_o[ERL_POS] && !stat_o[IE_POS] && !dbg_mode_o && !redirect_o));
endmodule

// File: tb/irq_ret_ctrl_tb_top.sv
module irq_ret_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        valid = 1'b0, ll_load = 1'b0;
   logic [2:0]  op = '0;
   logic [31:0] wdata = '0, epc = 32'h0000_1000, errpc = 32'h0000_2000;
   logic [31:0] depc = 32'h0000_3000, lladdr = '0;
   logic [31:0] new_pc, old_stat, stat, ll_out;
   logic        redirect, resync, done, bad, dbg;

   int n_chk = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_ret_ctrl dut_i (
      .clk_i (clk), .rst_ni (rst_n), .cmd_valid_i (valid), .cmd_op_i (op),
      .wr_data_i (wdata), .exc_pc_i (epc), .err_pc_i (errpc), .dbg_pc_i (depc),
      .ll_load_i (ll_load), .ll_addr_i (lladdr), .new_pc_o (new_pc),
      .redirect_o (redirect), .resync_o (resync), .done_o (done),
      .bad_cmd_o (bad), .old_stat_o (old_stat), .stat_o (stat),
      .dbg_mode_o (dbg), .ll_addr_o (ll_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   // drive at negedge, sample 1 time unit after the edge that takes the command
   task automatic issue(input logic [2:0] o, input logic ld, input logic [31:0] la);
      @(negedge clk);
      valid = 1'b1; op = o; ll_load = ld; lladdr = la;
      @(posedge clk);
      #1;
      valid = 1'b0; ll_load = 1'b0;
   endtask

   task automatic idle_cycle();
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      chk("R1 stat", stat, 32'h4);
      chk("R1 dbg", {31'b0, dbg}, 0);
      chk("R1 ll", ll_out, 0);
      chk("R1 pulses", {28'b0, redirect, resync, done, bad}, 0);
   endtask

   task automatic t_eret_erl();
      issue(3'd2, 1'b0, 0);
      chk("R4 pc", new_pc, 32'h2000);
      chk("R4 redirect", {31'b0, redirect}, 1);
      chk("R4 stat", stat, 32'h0);
      chk("R8 ll after eret", ll_out, 1);
      chk("R13 done", {31'b0, done}, 1);
      idle_cycle();
      chk("R13 redirect drops", {31'b0, redirect}, 0);
      chk("R13 done drops", {31'b0, done}, 0);
   endtask

   task automatic t_write();
      wdata = 32'h0000_00F2;
      issue(3'd4, 1'b0, 0);
      chk("R9 stat", stat, 32'hF2);
      chk("R9 old", old_stat, 32'h0);
      chk("R9 no redirect", {31'b0, redirect}, 0);
   endtask

   task automatic t_irq();
      issue(3'd1, 1'b0, 0);
      chk("R3 stat", stat, 32'hF3);
      chk("R3 old", old_stat, 32'hF2);
      chk("R3 resync", {31'b0, resync}, 1);
      issue(3'd0, 1'b0, 0);
      chk("R2 stat", stat, 32'hF2);
      chk("R2 old", old_stat, 32'hF3);
      chk("R2 resync", {31'b0, resync}, 1);
      idle_cycle();
      chk("R13 resync drops", {31'b0, resync}, 0);
   endtask

   task automatic t_ll_load();
      @(negedge clk); ll_load = 1'b1; lladdr = 32'h0000_ABC0;
      @(posedge clk); #1; ll_load = 1'b0;
      chk("R12 ll load", ll_out, 32'hABC0);
   endtask

   task automatic t_eret_exl();
      issue(3'd2, 1'b0, 0);
      chk("R5 pc", new_pc, 32'h1000);
      chk("R5 stat", stat, 32'hF0);
      chk("R8 ll after eret", ll_out, 1);
   endtask

   task automatic t_eret_both();
      wdata = 32'h6;
      issue(3'd4, 1'b0, 0);
      errpc = 32'h0000_2468;
      issue(3'd2, 1'b0, 0);
      chk("R4 both pc", new_pc, 32'h2468);
      chk("R4 both stat keeps exl", stat, 32'h2);
   endtask

   task automatic t_deret_bad();
      @(negedge clk); ll_load = 1'b1; lladdr = 32'h55;
      @(posedge clk); #1; ll_load = 1'b0;
      issue(3'd3, 1'b0, 0);
      chk("R7 bad", {31'b0, bad}, 1);
      chk("R7 no redirect", {31'b0, redirect}, 0);
      chk("R7 stat", stat, 32'h2);
      chk("R7 ll", ll_out, 32'h55);
      chk("R7 dbg", {31'b0, dbg}, 0);
      chk("R7 pc held", new_pc, 32'h2468);
   endtask

   task automatic t_debug();
      issue(3'd5, 1'b0, 0);
      chk("R10 dbg", {31'b0, dbg}, 1);
      chk("R10 stat", stat, 32'h2);
      issue(3'd3, 1'b1, 32'h77);
      chk("R6 pc", new_pc, 32'h3000);
      chk("R6 redirect", {31'b0, redirect}, 1);
      chk("R6 dbg cleared", {31'b0, dbg}, 0);
      chk("R6 stat", stat, 32'h2);
      chk("R12 return beats load", ll_out, 1);
   endtask

   task automatic t_reserved();
      for (int k = 6; k < 8; k++) begin
         issue(3'(k), 1'b0, 0);
         chk("R11 bad", {31'b0, bad}, 1);
         chk("R11 stat", stat, 32'h2);
         chk("R11 no redirect", {31'b0, redirect}, 0);
         chk("R11 old", old_stat, 32'h2);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      t_reset();
      t_eret_erl();
      t_write();
      t_irq();
      t_ll_load();
      t_eret_exl();
      t_eret_both();
      t_deret_bad();
      t_debug();
      t_reserved();
      idle_cycle();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule